// File: doc/BRIEF.md
# Two-Level Warp Scheduler

This block picks at most one warp to issue on every clock. It arbitrates only over a small pool of active warps drawn from a larger set of resident warps. Each resident warp sits in one of three states, and each warp has its own small state machine. While a warp is in `W_ACTIVE` it may be selected whenever its ready bit is high. When the warp issues a long-latency operation (for example a global load), the `DEMOTE` transition moves it to `W_PENDING` and frees its active slot. An attached register cache receives a single-cycle evict pulse with that warp's ID. When the operation finishes, a completion pulse fires the `COMPLETE` transition: the warp moves to `W_QUEUED` and joins the tail of a return queue.

On any clock where the active pool holds fewer warps than its capacity, the `PROMOTE` transition moves the warp at the head of the return queue back to `W_ACTIVE`, and a promote pulse tells the register cache which warp arrived. A short stall, such as an ALU result or a scratchpad access, is expressed only by the ready bit falling. It never costs the warp its active slot. Among ready active warps, selection rotates round-robin, starting just after the warp that issued last.

Top module: `warp_sched2l`

## Requirements
- R1: After reset, warps 0 to ACTIVE_SLOTS-1 are in `W_ACTIVE`, every other warp is in `W_QUEUED` with the return queue holding them in ascending ID order, the round-robin pointer is at warp NUM_WARPS-1, and both event pulses are low.
- R2: `issue_valid_o` is high exactly when at least one warp is both active and ready. `issue_wid_o` always names an active, ready warp, and warps that are not active never issue.
- R3: The issued warp is the first active, ready warp found by scanning upward (wrapping at NUM_WARPS) from the warp after the most recently issued one.
- R4: A `ll_issue_i` pulse naming an active warp demotes that warp. On the next cycle `evict_valid_o` is high for one cycle with `evict_wid_o` equal to that ID, and the warp no longer issues.
- R5: A `ll_issue_i` pulse naming a warp that is not active has no effect: no evict pulse follows and no state changes.
- R6: A `done_valid_i` pulse naming a pending warp moves it to the tail of the return queue. A completion naming a warp that is not pending is ignored.
- R7: Each cycle, if the count of active warps is below ACTIVE_SLOTS and the return queue is not empty, the head of the queue is promoted. On the next cycle `promote_valid_o` is high with `promote_wid_o` equal to that ID. At most one warp is promoted per cycle.
- R8: Every warp is in exactly one state, and the number of active warps never exceeds ACTIVE_SLOTS.
- R9: Dropping a warp's ready bit never demotes it. The warp stays active and issues again as soon as its ready bit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | NUM_WARPS | Per-warp ready bits |
| ll_issue_i | input | 1 | Long-latency operation issued this cycle |
| ll_wid_i | input | log2(NUM_WARPS) | Warp that issued the long-latency operation |
| done_valid_i | input | 1 | Long-latency completion this cycle |
| done_wid_i | input | log2(NUM_WARPS) | Warp whose operation completed |
| issue_valid_o | output | 1 | A warp is selected this cycle |
| issue_wid_o | output | log2(NUM_WARPS) | Selected warp |
| evict_valid_o | output | 1 | One-cycle flush request for the register cache |
| evict_wid_o | output | log2(NUM_WARPS) | Warp to flush |
| promote_valid_o | output | 1 | One-cycle notice that a warp entered the active pool |
| promote_wid_o | output | log2(NUM_WARPS) | Warp that entered the active pool |

## Verification
The hardest situation to reach from the ports is a fully drained active pool: every resident warp pending, the return queue empty and `issue_valid_o` low. Completions must then arrive in a chosen order so that promotion order can be told apart from ID order. The stimulus gets there by feeding a long-latency pulse for whichever warp the scheduler itself selects, on every cycle and with no completions, until all warps are pending. It then returns them in a scrambled order, interleaved with completions and long-latency pulses that must be ignored. A long random phase follows, with ready, demotion and completion traffic mixed so that demote, complete and promote events coincide on the same edge.

// File: rtl/warp_sched2l_pkg.sv
package warp_sched2l_pkg;

    typedef enum logic [1:0] {
        W_ACTIVE  = 2'd0,
        W_PENDING = 2'd1,
        W_QUEUED  = 2'd2
    } warp_state_e;

endpackage

// File: rtl/warp_ctx_fsm.sv
module warp_ctx_fsm
    import warp_sched2l_pkg::*;
#(
    parameter bit START_ACTIVE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        demote_i,
    input  logic        complete_i,
    input  logic        promote_i,
    output warp_state_e state_o
);

    warp_state_e state_q;
    warp_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= START_ACTIVE ? W_ACTIVE : W_QUEUED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: DEMOTE, COMPLETE, PROMOTE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_ACTIVE:  if (demote_i)   state_d = W_PENDING;
            W_PENDING: if (complete_i) state_d = W_QUEUED;
            W_QUEUED:  if (promote_i)  state_d = W_ACTIVE;
            default:                   state_d = W_QUEUED;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/warp_return_fifo.sv
module warp_return_fifo #(
    parameter int NUM_WARPS    = 32,
    parameter int ACTIVE_SLOTS = 8,
    localparam int WID_W       = $clog2(NUM_WARPS),
    localparam int CNT_W       = WID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WID_W-1:0] push_wid_i,
    input  logic             pop_i,
    output logic [WID_W-1:0] head_o,
    output logic             nonempty_o
);

    localparam int INIT_CNT = NUM_WARPS - ACTIVE_SLOTS;

    logic [WID_W-1:0] mem_q [NUM_WARPS];
    logic [WID_W-1:0] rd_q;
    logic [WID_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [WID_W-1:0] bump(input logic [WID_W-1:0] p);
        return (p == WID_W'(NUM_WARPS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WARPS; i++) begin
                mem_q[i] <= (i < INIT_CNT) ? WID_W'(i + ACTIVE_SLOTS) : '0;
            end
            rd_q  <= '0;
            wr_q  <= WID_W'(INIT_CNT % NUM_WARPS);
            cnt_q <= CNT_W'(INIT_CNT);
        end else begin
            if (push_i) begin
                mem_q[wr_q] <= push_wid_i;
                wr_q        <= bump(wr_q);
            end
            if (pop_i) begin
                rd_q <= bump(rd_q);
            end
            cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assign head_o     = mem_q[rd_q];
    assign nonempty_o = (cnt_q != '0);

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker #(
    parameter int NUM_WARPS = 32,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] req_i,
    input  logic [WID_W-1:0]     last_i,
    output logic                 gnt_valid_o,
    output logic [WID_W-1:0]     gnt_wid_o
);

    always_comb begin
        int unsigned idx;
        gnt_valid_o = 1'b0;
        gnt_wid_o   = '0;
        for (int off = 1; off <= NUM_WARPS; off++) begin
            idx = (int'(last_i) + off) % NUM_WARPS;
            if (!gnt_valid_o && req_i[idx]) begin
                gnt_valid_o = 1'b1;
                gnt_wid_o   = WID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_sched2l.sv
module warp_sched2l
    import warp_sched2l_pkg::*;
#(
    parameter int NUM_WARPS    = 32,
    parameter int ACTIVE_SLOTS = 8,
    localparam int WID_W       = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] ready_i,
    input  logic                 ll_issue_i,
    input  logic [WID_W-1:0]     ll_wid_i,
    input  logic                 done_valid_i,
    input  logic [WID_W-1:0]     done_wid_i,
    output logic                 issue_valid_o,
    output logic [WID_W-1:0]     issue_wid_o,
    output logic                 evict_valid_o,
    output logic [WID_W-1:0]     evict_wid_o,
    output logic                 promote_valid_o,
    output logic [WID_W-1:0]     promote_wid_o
);

    warp_state_e          wstate [NUM_WARPS];
    logic [NUM_WARPS-1:0] active_mask;
    logic [NUM_WARPS-1:0] pending_mask;
    logic [NUM_WARPS-1:0] queued_mask;

    logic                 demote_hit;
    logic                 complete_hit;
    logic                 pop;
    logic                 q_nonempty;
    logic [WID_W-1:0]     q_head;
    logic                 has_room;

    logic [WID_W-1:0]     last_q;
    logic                 pick_valid;
    logic [WID_W-1:0]     pick_wid;

    logic                 evict_v_q;
    logic [WID_W-1:0]     evict_w_q;
    logic                 prom_v_q;
    logic [WID_W-1:0]     prom_w_q;

    // per-warp state machines
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        warp_ctx_fsm #(
            .START_ACTIVE(g < ACTIVE_SLOTS)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .demote_i  (ll_issue_i   && (ll_wid_i   == WID_W'(g))),
            .complete_i(done_valid_i && (done_wid_i == WID_W'(g))),
            .promote_i (pop          && (q_head     == WID_W'(g))),
            .state_o   (wstate[g])
        );
        assign active_mask[g]  = (wstate[g] == W_ACTIVE);
        assign pending_mask[g] = (wstate[g] == W_PENDING);
        assign queued_mask[g]  = (wstate[g] == W_QUEUED);
    end

    assign demote_hit   = ll_issue_i   && active_mask[ll_wid_i];
    assign complete_hit = done_valid_i && pending_mask[done_wid_i];
    assign has_room     = ($countones(active_mask) < ACTIVE_SLOTS);
    assign pop          = q_nonempty && has_room;

    warp_return_fifo #(
        .NUM_WARPS   (NUM_WARPS),
        .ACTIVE_SLOTS(ACTIVE_SLOTS)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (complete_hit),
        .push_wid_i(done_wid_i),
        .pop_i     (pop),
        .head_o    (q_head),
        .nonempty_o(q_nonempty)
    );

    warp_rr_picker #(
        .NUM_WARPS(NUM_WARPS)
    ) u_pick (
        .req_i      (active_mask & ready_i),
        .last_i     (last_q),
        .gnt_valid_o(pick_valid),
        .gnt_wid_o  (pick_wid)
    );

    // round-robin pointer and event pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= WID_W'(NUM_WARPS - 1);
            evict_v_q <= 1'b0;
            evict_w_q <= '0;
            prom_v_q  <= 1'b0;
            prom_w_q  <= '0;
        end else begin
            if (pick_valid) last_q <= pick_wid;
            evict_v_q <= demote_hit;
            evict_w_q <= ll_wid_i;
            prom_v_q  <= pop;
            prom_w_q  <= q_head;
        end
    end

    // outputs
    always_comb begin
        issue_valid_o   = pick_valid;
        issue_wid_o     = pick_wid;
        evict_valid_o   = evict_v_q;
        evict_wid_o     = evict_w_q;
        promote_valid_o = prom_v_q;
        promote_wid_o   = prom_w_q;
    end

endmodule

// File: rtl/warp_sched2l_chk.sv
module warp_sched2l_chk #(
    parameter int NUM_WARPS    = 32,
    parameter int ACTIVE_SLOTS = 8,
    localparam int WID_W       = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] ready_i,
    input logic                 ll_issue_i,
    input logic [WID_W-1:0]     ll_wid_i,
    input logic                 done_valid_i,
    input logic [WID_W-1:0]     done_wid_i,
    input logic                 issue_valid_o,
    input logic [WID_W-1:0]     issue_wid_o,
    input logic                 evict_valid_o,
    input logic [WID_W-1:0]     evict_wid_o,
    input logic                 promote_valid_o,
    input logic [WID_W-1:0]     promote_wid_o,
    input logic [NUM_WARPS-1:0] active_mask,
    input logic [NUM_WARPS-1:0] pending_mask,
    input logic [NUM_WARPS-1:0] queued_mask
);

    assert_issue_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (active_mask[issue_wid_o] && ready_i[issue_wid_o]));

    assert_idle_when_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_mask & ready_i) == '0) |-> !issue_valid_o);

    assert_evict_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_issue_i && active_mask[ll_wid_i]) |=>
            (evict_valid_o && evict_wid_o == $past(ll_wid_i) && pending_mask[evict_wid_o]));

    assert_no_stray_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ll_issue_i && active_mask[ll_wid_i]) |=> !evict_valid_o);

    assert_done_queues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_i && pending_mask[done_wid_i]) |=> queued_mask[$past(done_wid_i)]);

    assert_promote_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        promote_valid_o |-> (active_mask[promote_wid_o] &&
                             $past($countones(active_mask)) < ACTIVE_SLOTS));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_mask) <= ACTIVE_SLOTS);

    assert_one_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_mask & pending_mask) == '0) && ((active_mask & queued_mask) == '0) &&
        ((pending_mask & queued_mask) == '0) &&
        ((active_mask | pending_mask | queued_mask) == '1));

endmodule

bind warp_sched2l warp_sched2l_chk #(
    .NUM_WARPS   (NUM_WARPS),
    .ACTIVE_SLOTS(ACTIVE_SLOTS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready_i        (ready_i),
    .ll_issue_i     (ll_issue_i),
    .ll_wid_i       (ll_wid_i),
    .done_valid_i   (done_valid_i),
    .done_wid_i     (done_wid_i),
    .issue_valid_o  (issue_valid_o),
    .issue_wid_o    (issue_wid_o),
    .evict_valid_o  (evict_valid_o),
    .evict_wid_o    (evict_wid_o),
    .promote_valid_o(promote_valid_o),
    .promote_wid_o  (promote_wid_o),
    .active_mask    (active_mask),
    .pending_mask   (pending_mask),
    .queued_mask    (queued_mask)
);

// File: tb/warp_sched2l_tb.sv
module warp_sched2l_tb_top;

    localparam int NW = 32;
    localparam int AS = 8;
    localparam int WW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] ready = '0;
    logic          ll_v = 1'b0;
    logic [WW-1:0] ll_w = '0;
    logic          dn_v = 1'b0;
    logic [WW-1:0] dn_w = '0;
    logic          issue_valid_o;
    logic [WW-1:0] issue_wid_o;
    logic          evict_valid_o;
    logic [WW-1:0] evict_wid_o;
    logic          promote_valid_o;
    logic [WW-1:0] promote_wid_o;

    always #10 clk = ~clk;  // 20 time units: 50 MHz

    warp_sched2l #(.NUM_WARPS(NW), .ACTIVE_SLOTS(AS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ready_i(ready),
        .ll_issue_i(ll_v), .ll_wid_i(ll_w),
        .done_valid_i(dn_v), .done_wid_i(dn_w),
        .issue_valid_o(issue_valid_o), .issue_wid_o(issue_wid_o),
        .evict_valid_o(evict_valid_o), .evict_wid_o(evict_wid_o),
        .promote_valid_o(promote_valid_o), .promote_wid_o(promote_wid_o)
    );

    // reference model: 0 active, 1 pending, 2 queued
    int n_cmp = 0;
    int n_bad = 0;
    int st [NW];
    int q [$];
    int last;
    bit exp_ev_v;
    int exp_ev_w;
    bit exp_pr_v;
    int exp_pr_w;
    bit finished = 0;

    function automatic int pick(logic [NW-1:0] r);
        for (int off = 1; off <= NW; off++) begin
            int i;
            i = (last + off) % NW;
            if (st[i] == 0 && r[i]) return i;
        end
        return -1;
    endfunction

    function automatic int n_active();
        int c = 0;
        for (int i = 0; i < NW; i++) if (st[i] == 0) c++;
        return c;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < NW; i++) begin
            st[i] = (i < AS) ? 0 : 2;
            if (i >= AS) q.push_back(i);
        end
        last = NW - 1;
        exp_ev_v = 0; exp_ev_w = 0; exp_pr_v = 0; exp_pr_w = 0;
    endtask

    task automatic step(logic [NW-1:0] r, bit l, int lw, bit d, int dw);
        int  e;
        bit  do_pop, do_ll, do_dn;
        ready = r; ll_v = l; ll_w = WW'(lw); dn_v = d; dn_w = WW'(dw);
        @(negedge clk);
        e = pick(r);
        check(issue_valid_o == (e >= 0), "R2 issue_valid", int'(issue_valid_o), int'(e >= 0));
        if (e >= 0)
            check(issue_wid_o == WW'(e), "R3 issue_wid", int'(issue_wid_o), e);
        check(evict_valid_o == exp_ev_v, "R4 R5 evict_valid", int'(evict_valid_o), int'(exp_ev_v));
        if (exp_ev_v)
            check(evict_wid_o == WW'(exp_ev_w), "R4 evict_wid", int'(evict_wid_o), exp_ev_w);
        check(promote_valid_o == exp_pr_v, "R7 promote_valid", int'(promote_valid_o), int'(exp_pr_v));
        if (exp_pr_v)
            check(promote_wid_o == WW'(exp_pr_w), "R7 promote_wid", int'(promote_wid_o), exp_pr_w);
        // model update from pre-edge state
        do_pop = (q.size() > 0) && (n_active() < AS);
        do_ll  = l && st[lw] == 0;
        do_dn  = d && st[dw] == 1;
        if (e >= 0) last = e;
        exp_ev_v = do_ll; exp_ev_w = lw;
        exp_pr_v = do_pop;
        if (do_pop) begin
            exp_pr_w = q.pop_front();
            st[exp_pr_w] = 0;
        end
        if (do_ll) st[lw] = 1;
        if (do_dn) begin
            st[dw] = 2;
            q.push_back(dw);
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int e;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: no event pulses while in reset
        check(!evict_valid_o && !promote_valid_o, "R1 reset pulses",
              int'(evict_valid_o | promote_valid_o), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R1 R3: all ready, rotation over warps 0..AS-1
        for (int k = 0; k < 12; k++) step('1, 0, 0, 0, 0);

        // R2 R9: sparse ready, then none, then return
        for (int k = 0; k < 6; k++) step(NW'(32'h0000_00A4), 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step('0, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) step(NW'(32'h0000_0011), 0, 0, 0, 0);

        // R5: long-latency on queued warp ignored
        step('1, 1, 20, 0, 0);
        // R6: completion on active warp ignored
        step('1, 0, 0, 1, 3);

        // R4 R7: demote whatever issues until every warp is pending
        for (int k = 0; k < 80; k++) begin
            e = pick('1);
            step('1, e >= 0, (e < 0) ? 0 : e, 0, 0);
        end
        step('1, 0, 0, 0, 0);  // R2: drained pool, no issue

        // R6 R7: scrambled completions, with ignored events in between
        for (int k = 0; k < NW; k++) begin
            step('1, 0, 0, 1, (k * 13 + 5) % NW);
            step('1, 1, (k * 13 + 5) % NW, 1, (k * 13 + 5) % NW);  // R5 R6 both ignored
        end
        for (int k = 0; k < 10; k++) step('1, 0, 0, 0, 0);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [NW-1:0] r;
            bit l, d;
            int lw, dw;
            r  = NW'($urandom);
            if ($urandom_range(3) == 0) r = '0;
            e  = pick(r);
            l  = ($urandom_range(3) == 0);
            lw = ($urandom_range(3) != 0 && e >= 0) ? e : int'($urandom_range(NW - 1));
            d  = ($urandom_range(2) == 0);
            dw = int'($urandom_range(NW - 1));
            step(r, l, lw, d, dw);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule